// File: doc/BRIEF.md
# Channel Command Decoder with Status Flags

This block sits between a host byte interface and a bank of playback engines. It decodes commands of one or two bytes from the host. Each channel command carries a channel mask in its low nibble. When a command is complete, the block issues a one-cycle control pulse on the selected channels and presents the command's argument byte. It also keeps two per-channel state bits, the loop-mode flags and the power state.

For each channel the block also builds an active-low status byte. One half reports "engine working" and the other half reports "engine waiting". While a command is being processed, every bit of the status byte is held low for a fixed number of clock cycles. The host interface marks the first byte of each command with `byte_first`. A new first byte therefore always restarts decoding, and any half-received command is dropped.

Top module: `chan_cmd_decoder`

## Requirements
- R1: Reset state. While `rst_n` is low, and after its release, every pulse output is 0, `loop_on` is 0, `pwr_on` and `pwr_soft` are 0, and `status` is all ones when `ch_playing` and `ch_waiting` are 0.
- R2: In every channel command, bit i of the low nibble of the first byte selects channel i+1 (bit 0 selects channel 1, bit 3 selects channel 4). Any combination of bits may be set, including none.
- R3: Play uses upper nibble 4'b0100 and needs a second byte, which is the phrase number (0 to 255). One cycle after the second byte is sampled, `play_go` equals the mask for one cycle and `cmd_arg` equals the phrase number.
- R4: The other two-byte commands are silence (4'b0111), volume (4'b1010) and pan (4'b1011). One cycle after the second byte, they pulse `sil_go`, `vol_we` and `pan_we` respectively with the mask, and `cmd_arg` equals the second byte.
- R5: The one-byte commands are start (4'b0101) and stop (4'b0110). One cycle after the byte, they pulse `start_go` and `stop_go` respectively with the mask, and `cmd_arg` reads 0. At most one kind of pulse is active in any cycle.
- R6: Loop set (4'b1000) sets `loop_on` for the masked channels. Loop clear (4'b1001) and stop both clear it for the masked channels. Unmasked channels keep their flags.
- R7: Power commands have upper nibble 4'b0000 and low nibble 4'b00ds. With d=0 the block powers up and with d=1 it powers down, so `pwr_on` = !d. `pwr_soft` takes the value of s. A power command whose low nibble bits 3:2 are not both 0 is ignored.
- R8: Some bytes are ignored and start no processing: a byte with `byte_first`=1 and an undefined upper nibble (4'b0001-4'b0011 or 4'b1100-4'b1111), and a byte with `byte_first`=0 when no second byte is pending. A first byte that arrives while a second byte is pending drops the pending command.
- R9: `status` bit 4+i is BUSY for channel i+1 and bit i is NCR for channel i+1. When no command is being processed, BUSY is the inverse of `ch_playing[i]` and NCR is the inverse of `ch_waiting[i]`.
- R10: Each executed command forces every `status` bit to 0 for exactly PROC_CYCLES cycles, starting in the cycle in which its pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A host byte is present this cycle |
| byte_first | input | 1 | The byte present is the first byte of a command |
| byte_data | input | 8 | Host byte |
| ch_playing | input | NCH | Engine i is producing sound |
| ch_waiting | input | NCH | Engine i holds a queued phrase |
| play_go | output | NCH | One-cycle play pulse per channel |
| start_go | output | NCH | One-cycle start pulse per channel |
| stop_go | output | NCH | One-cycle stop pulse per channel |
| sil_go | output | NCH | One-cycle silence-insert pulse per channel |
| vol_we | output | NCH | One-cycle volume write per channel |
| pan_we | output | NCH | One-cycle pan write per channel |
| cmd_arg | output | 8 | Argument byte of the latest command |
| loop_on | output | NCH | Loop-mode flag per channel |
| pwr_on | output | 1 | Powered-up state |
| pwr_soft | output | 1 | Latest power change used pop suppression |
| status | output | 2*NCH | {BUSY[NCH-1:0], NCR[NCH-1:0]}, active low |

## Verification
The bench sends a play command and then, before the phrase byte, a new first byte. A decoder that did not restart would pulse play with that byte as the phrase instead of running the new start command. It also sends a stray continuation byte and unknown opcodes. A design that treated these as commands would pulse some channel or pull the status low. The length of the status hold is checked on both sides of its end, so a counter that is off by one fails either the last low cycle or the first released cycle. Stop is applied to channels that are looping, so a design that left the loop flag set, or cleared unmasked channels, shows up on `loop_on`.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

   typedef enum logic [3:0] {
      OP_PWR   = 4'h0,
      OP_PLAY  = 4'h4,
      OP_START = 4'h5,
      OP_STOP  = 4'h6,
      OP_SIL   = 4'h7,
      OP_LSET  = 4'h8,
      OP_LCLR  = 4'h9,
      OP_VOL   = 4'hA,
      OP_PAN   = 4'hB
   } op_e;

   typedef struct packed {
      logic       vld;
      logic [3:0] op;
      logic [3:0] sub;
      logic [7:0] arg;
   } exec_t;

   function automatic logic op_two(input logic [3:0] op);
      return (op == OP_PLAY) || (op == OP_SIL) || (op == OP_VOL) || (op == OP_PAN);
   endfunction

   function automatic logic op_single(input logic [3:0] op, input logic [3:0] sub);
      case (op)
         OP_PWR:                             return sub[3:2] == 2'b00;
         OP_START, OP_STOP, OP_LSET, OP_LCLR: return 1'b1;
         default:                            return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cmdec_frame.sv
module cmdec_frame
   import cmdec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_valid,
   input  logic       byte_first,
   input  logic [7:0] byte_data,
   output exec_t      ex
);

   logic       pend_q, pend_d;
   logic [3:0] pop_q, pop_d;
   logic [3:0] psub_q, psub_d;

   always_comb begin
      ex     = '0;
      pend_d = pend_q;
      pop_d  = pop_q;
      psub_d = psub_q;
      if (byte_valid && byte_first) begin
         pop_d  = byte_data[7:4];
         psub_d = byte_data[3:0];
         if (op_two(byte_data[7:4])) begin
            pend_d = 1'b1;
         end else begin
            pend_d = 1'b0;
            if (op_single(byte_data[7:4], byte_data[3:0])) begin
               ex.vld = 1'b1;
               ex.op  = byte_data[7:4];
               ex.sub = byte_data[3:0];
               ex.arg = 8'h00;
            end
         end
      end else if (byte_valid && pend_q) begin
         pend_d = 1'b0;
         ex.vld = 1'b1;
         ex.op  = pop_q;
         ex.sub = psub_q;
         ex.arg = byte_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pop_q  <= '0;
         psub_q <= '0;
      end else begin
         pend_q <= pend_d;
         pop_q  <= pop_d;
         psub_q <= psub_d;
      end
   end

endmodule

// File: rtl/cmdec_exec.sv
module cmdec_exec
   import cmdec_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  exec_t          ex,
   output logic [NCH-1:0] play_go,
   output logic [NCH-1:0] start_go,
   output logic [NCH-1:0] stop_go,
   output logic [NCH-1:0] sil_go,
   output logic [NCH-1:0] vol_we,
   output logic [NCH-1:0] pan_we,
   output logic [7:0]     cmd_arg,
   output logic [NCH-1:0] loop_on,
   output logic           pwr_on,
   output logic           pwr_soft
);

   logic [NCH-1:0] mask;
   assign mask = ex.sub[NCH-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         play_go  <= '0;
         start_go <= '0;
         stop_go  <= '0;
         sil_go   <= '0;
         vol_we   <= '0;
         pan_we   <= '0;
         cmd_arg  <= '0;
         pwr_on   <= 1'b0;
         pwr_soft <= 1'b0;
      end else begin
         play_go  <= '0;
         start_go <= '0;
         stop_go  <= '0;
         sil_go   <= '0;
         vol_we   <= '0;
         pan_we   <= '0;
         if (ex.vld) begin
            cmd_arg <= ex.arg;
            case (ex.op)
               OP_PLAY:  play_go  <= mask;
               OP_START: start_go <= mask;
               OP_STOP:  stop_go  <= mask;
               OP_SIL:   sil_go   <= mask;
               OP_VOL:   vol_we   <= mask;
               OP_PAN:   pan_we   <= mask;
               OP_PWR: begin
                  pwr_on   <= ~ex.sub[1];
                  pwr_soft <= ex.sub[0];
               end
               default: ;
            endcase
         end
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_loop
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            loop_on[i] <= 1'b0;
         end else if (ex.vld && ex.sub[i]) begin
            if (ex.op == OP_LSET)
               loop_on[i] <= 1'b1;
            else if ((ex.op == OP_LCLR) || (ex.op == OP_STOP))
               loop_on[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cmdec_status.sv
module cmdec_status #(
   parameter int NCH         = 4,
   parameter int PROC_CYCLES = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NCH-1:0]   ch_playing,
   input  logic [NCH-1:0]   ch_waiting,
   output logic [2*NCH-1:0] status
);

   localparam int CNT_W = $clog2(PROC_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROC_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             proc;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign proc   = (cnt_q != '0);
   assign status = proc ? '0 : {~ch_playing, ~ch_waiting};

endmodule

// File: rtl/chan_cmd_decoder.sv
module chan_cmd_decoder
   import cmdec_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int PROC_CYCLES = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             byte_first,
   input  logic [7:0]       byte_data,
   input  logic [NCH-1:0]   ch_playing,
   input  logic [NCH-1:0]   ch_waiting,
   output logic [NCH-1:0]   play_go,
   output logic [NCH-1:0]   start_go,
   output logic [NCH-1:0]   stop_go,
   output logic [NCH-1:0]   sil_go,
   output logic [NCH-1:0]   vol_we,
   output logic [NCH-1:0]   pan_we,
   output logic [7:0]       cmd_arg,
   output logic [NCH-1:0]   loop_on,
   output logic             pwr_on,
   output logic             pwr_soft,
   output logic [2*NCH-1:0] status
);

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("NCH must lie in 1..4, the mask is one nibble");
   end
   if (PROC_CYCLES < 1) begin : g_bad_proc
      $error("PROC_CYCLES must be at least 1");
   end

   exec_t ex;

   cmdec_frame u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_first (byte_first),
      .byte_data  (byte_data),
      .ex         (ex)
   );

   cmdec_exec #(.NCH(NCH)) u_exec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ex       (ex),
      .play_go  (play_go),
      .start_go (start_go),
      .stop_go  (stop_go),
      .sil_go   (sil_go),
      .vol_we   (vol_we),
      .pan_we   (pan_we),
      .cmd_arg  (cmd_arg),
      .loop_on  (loop_on),
      .pwr_on   (pwr_on),
      .pwr_soft (pwr_soft)
   );

   cmdec_status #(.NCH(NCH), .PROC_CYCLES(PROC_CYCLES)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (ex.vld),
      .ch_playing (ch_playing),
      .ch_waiting (ch_waiting),
      .status     (status)
   );

endmodule

// File: rtl/chan_cmd_decoder_chk.sv
module chan_cmd_decoder_chk #(
   parameter int NCH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_valid,
   input logic             byte_first,
   input logic [NCH-1:0]   play_go,
   input logic [NCH-1:0]   start_go,
   input logic [NCH-1:0]   stop_go,
   input logic [NCH-1:0]   sil_go,
   input logic [NCH-1:0]   vol_we,
   input logic [NCH-1:0]   pan_we,
   input logic [NCH-1:0]   loop_on,
   input logic             pwr_on,
   input logic [2*NCH-1:0] status
);

   logic any_go, tail_go;
   assign any_go  = |{play_go, start_go, stop_go, sil_go, vol_we, pan_we};
   assign tail_go = |{play_go, sil_go, vol_we, pan_we};

   AST_PULSE_HIDES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      any_go |-> (status == '0));  // R10

   AST_ONE_PULSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|play_go, |start_go, |stop_go, |sil_go, |vol_we, |pan_we}));  // R5

   AST_STOP_DROPS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
      ((stop_go & loop_on) == '0));  // R6

   AST_TAIL_FROM_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      tail_go |-> $past(byte_valid && !byte_first));  // R8

   AST_LOOP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((loop_on & ~$past(loop_on)) != '0) |-> $past(byte_valid && byte_first));  // R6

   AST_PWR_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_on) |-> $past(byte_valid && byte_first));  // R7

endmodule

bind chan_cmd_decoder chan_cmd_decoder_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_valid (byte_valid),
   .byte_first (byte_first),
   .play_go    (play_go),
   .start_go   (start_go),
   .stop_go    (stop_go),
   .sil_go     (sil_go),
   .vol_we     (vol_we),
   .pan_we     (pan_we),
   .loop_on    (loop_on),
   .pwr_on     (pwr_on),
   .status     (status)
);

// File: tb/chan_cmd_decoder_bench.sv
module chan_cmd_decoder_bench;

   localparam int NCH = 4;
   localparam int PC  = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_valid = 1'b0;
   logic       byte_first = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [3:0] ch_playing = 4'h0;
   logic [3:0] ch_waiting = 4'h0;
   logic [3:0] play_go, start_go, stop_go, sil_go, vol_we, pan_we, loop_on;
   logic [7:0] cmd_arg, status;
   logic       pwr_on, pwr_soft;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   chan_cmd_decoder #(.NCH(NCH), .PROC_CYCLES(PC)) u_chan_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
      .byte_data(byte_data), .ch_playing(ch_playing), .ch_waiting(ch_waiting),
      .play_go(play_go), .start_go(start_go), .stop_go(stop_go), .sil_go(sil_go),
      .vol_we(vol_we), .pan_we(pan_we), .cmd_arg(cmd_arg), .loop_on(loop_on),
      .pwr_on(pwr_on), .pwr_soft(pwr_soft), .status(status)
   );

   // {first byte, second byte, two-byte flag, {play,start,stop,sil,vol,pan}, arg}
   localparam int VN = 8;
   localparam logic [48:0] VEC [VN] = '{
      {8'h43, 8'h7E, 1'b1, 24'h300000, 8'h7E},  // R3 play ch1+ch2
      {8'h5C, 8'h00, 1'b0, 24'h0C0000, 8'h00},  // R5 start ch3+ch4
      {8'h61, 8'h00, 1'b0, 24'h001000, 8'h00},  // R5 stop ch1
      {8'h7F, 8'h20, 1'b1, 24'h000F00, 8'h20},  // R4 silence all
      {8'hA4, 8'h1F, 1'b1, 24'h000040, 8'h1F},  // R4 volume ch3
      {8'hB8, 8'h5A, 1'b1, 24'h000008, 8'h5A},  // R4 pan ch4
      {8'h40, 8'h00, 1'b1, 24'h000000, 8'h00},  // R2 empty mask
      {8'h4F, 8'hFF, 1'b1, 24'hF00000, 8'hFF}   // R3 phrase 255
   };

   function automatic logic [23:0] goes();
      return {play_go, start_go, stop_go, sil_go, vol_we, pan_we};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input logic first);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = b;
      byte_first = first;
      @(negedge clk);
      byte_valid = 1'b0;
      byte_first = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      idle(3);
      check("R1 pulses in reset", {8'h0, goes()}, 32'h0);
      rst_n = 1'b1;
      idle(1);
      check("R1 pulses", {8'h0, goes()}, 32'h0);
      check("R1 loop", loop_on, 0);
      check("R1 power", {pwr_on, pwr_soft}, 0);
      check("R1 status idle", status, 8'hFF);

      for (int k = 0; k < VN; k++) begin
         put(VEC[k][48:41], 1'b1);
         if (VEC[k][32]) put(VEC[k][40:33], 1'b0);
         check("R2 R3 R4 R5 pulses", {8'h0, goes()}, {8'h0, VEC[k][31:8]});
         check("R3 R4 arg", cmd_arg, VEC[k][7:0]);
         check("R10 status held", status, 8'h00);
         idle(1);
         check("R5 pulse single cycle", {8'h0, goes()}, 32'h0);
         idle(PC);
      end

      // R10 hold length
      put(8'h53, 1'b1);
      idle(PC - 1);
      check("R10 last held cycle", status, 8'h00);
      idle(1);
      check("R10 released", status, 8'hFF);

      // R6 loop set, clear, stop
      put(8'h85, 1'b1);
      check("R6 set", loop_on, 4'b0101);
      idle(PC);
      put(8'h94, 1'b1);
      check("R6 clear", loop_on, 4'b0001);
      idle(PC);
      put(8'h8F, 1'b1);
      idle(PC);
      put(8'h63, 1'b1);
      check("R6 stop clears", loop_on, 4'b1100);
      check("R6 stop pulse", stop_go, 4'b0011);
      idle(PC);

      // R7 power
      put(8'h01, 1'b1);
      check("R7 soft up", {pwr_on, pwr_soft}, 2'b11);
      idle(PC);
      put(8'h02, 1'b1);
      check("R7 hard down", {pwr_on, pwr_soft}, 2'b00);
      idle(PC);
      put(8'h0C, 1'b1);
      check("R7 bad power ignored", {pwr_on, pwr_soft}, 2'b00);
      check("R7 bad power no busy", status, 8'hFF);

      // R8 restart, stray byte, unknown opcode
      put(8'h4F, 1'b1);
      check("R8 first byte only", {8'h0, goes()}, 32'h0);
      put(8'h52, 1'b1);
      check("R8 restart start", {8'h0, goes()}, 32'h00020000);
      idle(PC);
      put(8'h33, 1'b0);
      check("R8 stray byte pulses", {8'h0, goes()}, 32'h0);
      check("R8 stray byte status", status, 8'hFF);
      put(8'hC5, 1'b1);
      check("R8 unknown pulses", {8'h0, goes()}, 32'h0);
      check("R8 unknown status", status, 8'hFF);
      put(8'h11, 1'b0);
      check("R8 unknown leaves nothing pending", {8'h0, goes()}, 32'h0);

      // R9 status mapping
      ch_playing = 4'b0101;
      ch_waiting = 4'b0010;
      idle(1);
      check("R9 status map", status, 8'hAD);
      put(8'h61, 1'b1);
      check("R10 forced low over engines", status, 8'h00);
      idle(PC);
      check("R9 status back", status, 8'hAD);

      summary();
   end

endmodule